// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial slave that accepts only block-write transactions and uses them to load a small bank of 8-bit configuration registers. A controller sends a start, the slave's 7-bit address with the write bit, a command code and a byte count, and then the data bytes. The slave acknowledges the address and each byte after it. It ignores the values of the command code and the byte count, but both bytes must be present. The first data byte always goes to register 0, and each later byte goes to the next register up. Indexed access is not possible.

A transfer may end with a stop after any complete byte, and every byte finished before the stop is kept. A repeated start or a stop returns the slave to address matching. Data bytes beyond the implemented registers are acknowledged and dropped. The bus pins pass through synchronizers into the system clock domain. The data line is modelled as open-drain: the block never drives it high, and it pulls the line low only during its acknowledge slots.

Top module: `cfg_blockwr_slave`

## Requirements
- R1: Only the address byte 0xD2 (7-bit address 1101001, then write bit 0) is acknowledged. Any other address byte, including 0xD3 (the read bit set), gets no acknowledge, and the rest of that transfer changes no register.
- R2: After a matching address, the slave pulls the data line low for the whole ninth clock of the address byte and of every byte that follows. It releases the line at the end of that clock.
- R3: The two bytes after the address are taken as the command code and the byte count. Any values are accepted, and neither value changes which register the data goes to.
- R4: Data bytes are received most significant bit first. The k-th data byte of a transfer (k starting at 0) is written to register k. Register k appears at cfg_q[8k+7:8k].
- R5: A stop after any complete data byte ends the transfer. All data bytes completed before the stop are kept, and the registers not reached are unchanged.
- R6: A data byte cut short by a stop is not written, and its register keeps its old value.
- R7: Data bytes beyond the sixth are acknowledged and discarded. All six registers then hold the first six data bytes.
- R8: A repeated start, whether sent mid-transfer or after an unmatched address, returns the slave to address matching. The next transfer again starts at register 0.
- R9: After reset the registers read, from register 0 up: 0x06, 0xFF, 0xFF, 0x8A, 0x02, 0x00.
- R10: A synchronous reset asserted in the middle of a transfer restores the defaults of R9 and releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High to pull the data line low (acknowledge) |
| cfg_q | output | 48 | Register contents, register k at bits 8k+7:8k |

## Verification
The bench sweeps all 128 seven-bit addresses with the write bit and also sends the read-direction address. A slave that checked only part of the address, or ignored the direction bit, would acknowledge the wrong byte or let it write registers. Transfers of one to eight data bytes use varied command codes and byte counts. These catch a design that indexes by the command code, that takes the byte count as data, or that wraps around or writes past the last register. A stop in the middle of a byte, repeated starts mid-transfer and after an unmatched address, and a reset in the middle of a byte test the recovery paths. If any of these went wrong, a partial byte would be written, data would continue at the old index, or the line would stay pulled low.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_ACKWAIT,
    S_ACK,
    S_IGNORE
  } rx_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_DATA
  } rx_phase_t;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign sda_lvl   = sda_s;
  // start: data falls while clock stays high; stop: data rises while clock stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
endmodule

// File: rtl/bw_engine.sv
module bw_engine
  import cfgw_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          ADDR_W   = 7,
  parameter int          NREG     = 6,
  parameter logic [6:0]  SLV_ADDR = 7'h69,
  localparam int         BW       = $clog2(DW),
  localparam int         IW       = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          scl_rise,
  input  logic          scl_fall,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data
);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);
  localparam logic [IW-1:0] REG_LIM  = IW'(NREG);

  rx_state_t     state;
  rx_phase_t     phase;
  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] shreg, nxt_byte;
  logic [IW-1:0] idx;
  logic          addr_ok;

  assign nxt_byte = {shreg[DW-2:0], sda_lvl};
  assign addr_ok  = (nxt_byte[DW-1 -: ADDR_W] == SLV_ADDR) && !nxt_byte[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      idx     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= S_RECV;
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        idx     <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RECV: begin
            if (scl_rise) begin
              shreg <= nxt_byte;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                state   <= S_ACKWAIT;
                case (phase)
                  PH_ADDR: begin
                    if (addr_ok) phase <= PH_CMD;
                    else         state <= S_IGNORE;
                  end
                  PH_CMD:   phase <= PH_COUNT;
                  PH_COUNT: phase <= PH_DATA;
                  default: begin
                    // data byte complete: commit only now, drop past the bank
                    if (idx < REG_LIM) begin
                      wr_en   <= 1'b1;
                      wr_idx  <= idx;
                      wr_data <= nxt_byte;
                      idx     <= idx + 1'b1;
                    end
                  end
                endcase
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          S_ACKWAIT: begin
            if (scl_fall) begin
              sda_oe <= 1'b1;
              state  <= S_ACK;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the line is only pulled after a falling clock edge was seen
  p_ack_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R7: writes never address beyond the implemented bank
  p_write_bounds_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < REG_LIM));
  // R8: a stop releases the line and returns to idle
  p_release_on_stop_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && state == S_IDLE));
  // R1: an unmatched transfer stays silent
  p_ignore_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IGNORE) |=> (!wr_en && !sda_oe));
  // R6: a write can only follow a rising clock edge in receive
  p_write_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(scl_rise) && $past(state) == S_RECV));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int                 DW       = 8,
  parameter int                 NREG     = 6,
  parameter logic [NREG*DW-1:0] DEFAULTS = '0,
  localparam int                IW       = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        q[i*DW +: DW] <= DEFAULTS[i*DW +: DW];
      else if (wr_en && wr_idx == IW'(i))
        q[i*DW +: DW] <= wr_data;
    end
  end

  // R9: the cycle after reset the bank holds its defaults
  p_defaults_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == DEFAULTS));
  // R6: without a write the bank holds its contents
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(q));
endmodule

// File: rtl/cfg_blockwr_slave.sv
module cfg_blockwr_slave #(
  parameter int                 DW          = 8,
  parameter int                 NREG        = 6,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [6:0]         SLV_ADDR    = 7'h69,
  parameter logic [NREG*DW-1:0] DEFAULTS    = 48'h00_02_8A_FF_FF_06,
  localparam int                IW          = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] cfg_q
);
  logic          sda_lvl, start_det, stop_det, scl_rise, scl_fall;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  bw_engine #(.DW(DW), .ADDR_W(7), .NREG(NREG), .SLV_ADDR(SLV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .start_det(start_det),
    .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_regbank #(.DW(DW), .NREG(NREG), .DEFAULTS(DEFAULTS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .q(cfg_q)
  );
endmodule

// File: tb/cfg_blockwr_slave_test.sv
module cfg_blockwr_slave_test;
  localparam int H = 8;
  localparam logic [47:0] DEF = 48'h00_02_8A_FF_FF_06;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] cfg_q;
  logic [47:0] exp_q;
  wire sda_line = sda_m & ~sda_oe;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_blockwr_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send_start();
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0;   tick(H);
  endtask

  task automatic send_stop();
    sda_m = 1'b0; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;  tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H/2);
    ack = ~sda_line;
    tick(H/2);
    scl = 1'b0;   tick(H);
  endtask

  // full block write; data byte k = seed + 29*k
  task automatic write_tx(input logic [7:0] cmd, input logic [7:0] cnt, input int n, input logic [7:0] seed);
    logic a;
    send_start();
    send_byte(8'hD2, a); chk(a, "R2 addr ack", {47'd0, a}, 48'd1);
    send_byte(cmd, a);   chk(a, "R3 cmd ack", {47'd0, a}, 48'd1);
    send_byte(cnt, a);   chk(a, "R3 count ack", {47'd0, a}, 48'd1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(seed + 8'(29 * k));
      send_byte(d, a);
      chk(a, (k >= 6) ? "R7 extra byte ack" : "R2 data ack", {47'd0, a}, 48'd1);
      if (k < 6) exp_q[k*8 +: 8] = d;
    end
    send_stop();
  endtask

  initial begin
    logic a;
    exp_q = DEF;
    tick(5);
    rst = 1'b0;
    tick(4);
    chk(cfg_q == DEF, "R9 reset defaults", cfg_q, DEF);
    chk(sda_oe == 1'b0, "R9 line released", {47'd0, sda_oe}, 48'd0);

    // R1: sweep every 7-bit address with write bit
    for (int ad = 0; ad < 128; ad++) begin
      send_start();
      send_byte({7'(ad), 1'b0}, a);
      chk(a == (ad == 'h69), "R1 address sweep", {47'd0, a}, {47'd0, ad == 'h69});
      send_stop();
    end
    chk(cfg_q == exp_q, "R1 regs after sweep", cfg_q, exp_q);

    // R1: read direction is not acknowledged and writes nothing
    send_start();
    send_byte(8'hD3, a);
    chk(!a, "R1 read bit nack", {47'd0, a}, 48'd0);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    send_byte(8'h55, a);
    send_byte(8'hAA, a);
    send_stop();
    chk(cfg_q == exp_q, "R1 no write after nack", cfg_q, exp_q);

    // R3 R4 R5 R7: lengths 1..8 with varied command and count
    for (int n = 1; n <= 8; n++) begin
      write_tx(8'(n * 37), (n % 2 == 0) ? 8'hFF : 8'(n), n, 8'(n * 16 + 3));
      tick(4);
      chk(cfg_q == exp_q, n > 6 ? "R7 regs after long write" : "R4 R5 regs after write",
          cfg_q, exp_q);
    end

    // R6: stop in the middle of a data byte
    send_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    send_byte(8'h3C, a);
    exp_q[7:0] = 8'h3C;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    send_stop();
    tick(4);
    chk(cfg_q == exp_q, "R6 partial byte dropped", cfg_q, exp_q);

    // R8: repeated start mid-transfer restarts at register 0
    send_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h03, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    exp_q[15:0] = 16'h2211;
    send_start();
    send_byte(8'hD2, a);
    chk(a, "R8 ack after repeated start", {47'd0, a}, 48'd1);
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    send_byte(8'h77, a);
    exp_q[7:0] = 8'h77;
    send_stop();
    tick(4);
    chk(cfg_q == exp_q, "R8 restart at register 0", cfg_q, exp_q);

    // R8: repeated start after an unmatched address
    send_start();
    send_byte(8'hA4, a);
    chk(!a, "R1 wrong address nack", {47'd0, a}, 48'd0);
    send_start();
    send_byte(8'hD2, a);
    chk(a, "R8 recover after nack", {47'd0, a}, 48'd1);
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    send_byte(8'h9E, a);
    exp_q[7:0] = 8'h9E;
    send_stop();
    tick(4);
    chk(cfg_q == exp_q, "R8 regs after recovery", cfg_q, exp_q);

    // R10: reset in the middle of a transfer
    send_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    send_byte(8'h5A, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    rst = 1'b1; tick(3);
    rst = 1'b0; tick(2);
    exp_q = DEF;
    chk(cfg_q == DEF, "R10 defaults after reset", cfg_q, DEF);
    chk(sda_oe == 1'b0, "R10 line released", {47'd0, sda_oe}, 48'd0);
    send_stop();
    write_tx(8'h00, 8'h01, 1, 8'hC4);
    tick(4);
    chk(cfg_q == exp_q, "R10 usable after reset", cfg_q, exp_q);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule